// File: doc/BRIEF.md
# Horizontal OSD timing generator

This block produces the per-line horizontal timing for a character overlay. It runs on a pixel clock that is locked to an external line-sync pulse. Every rising edge of that pulse restarts a pixel position counter. Once the counter reaches a programmable start delay, the block opens a display window of 24 character cells. Each cell is 12 dots wide. While the window is open, the block reports the current character column and the dot inside that character. The rest of the line is blank.

A wide mode shows every dot for two pixel clocks. This doubles the window to 576 clocks. The line length is set by a resolution register in units of 12 pixel clocks. If the window would run past the end of the line, it is cut off there.

The start delay is six pixel clocks per step of the position register, plus 49. A fixed phase-detector pulse width, set at build time, is then subtracted. The result never goes below zero.

Top module: `osd_htiming`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs settle to `line_pos` all ones, `disp_en` low, `char_col` 0 and `char_dot` 0.
- R2: A rising edge of `line_sync` sampled at a clock edge makes `line_pos` read 0 in the next cycle. After that it rises by one each clock and stops at all ones. With the default parameters the counter is 13 bits wide, so it stops at 8191.
- R3: Let D = max(6*`hpos_reg` + 49 − PHASE_PULSE, 0). `disp_en` first goes high in the cycle where `line_pos` equals D.
- R4: With `wide_mode` low, `disp_en` stays high for 288 cycles. During that time `char_dot` counts 0 to 11 once per clock, and `char_col` goes up by one at each wrap, from 0 to 23.
- R5: With `wide_mode` high, the window lasts 576 cycles. Each `char_dot` value is held for two clocks, so one character spans 24 clocks. The column is (line_pos − D)/24 and the dot is ((line_pos − D) mod 24)/2.
- R6: `disp_en` is low whenever `line_pos` ≥ 12*`hres_reg`, even if the window has not yet ended.
- R7: `char_col` and `char_dot` read 0 whenever `disp_en` is low.
- R8: A new rising edge of `line_sync` in the middle of a window restarts the line. The next window starts again at column 0, dot 0.
- R9: Holding `line_sync` high does not restart the counter again. Only a low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | Line-sync pulse; its rising edge starts a line |
| hpos_reg | input | HPOS_W | Horizontal start position setting |
| hres_reg | input | HRES_W | Line length in units of 12 pixel clocks |
| wide_mode | input | 1 | Doubles each dot to two pixel clocks |
| disp_en | output | 1 | High while the character window is shown |
| char_col | output | 5 | Character column inside the window |
| char_dot | output | 4 | Dot index inside the current character |
| line_pos | output | CNT_W | Pixel clocks since the last line start |

## Verification
The assertions assume that `hpos_reg`, `hres_reg` and `wide_mode` hold steady while a window is open. The column and dot counters only follow those values incrementally. To respect this, the stimulus changes its settings only in the cycle right after a sync rising edge, when the counters have just been cleared. The assertions also assume nothing about the length of the sync pulse. For that reason the stimulus includes short pulses, a sync held high for most of a line, and a long stretch with no sync at all.

// File: rtl/osd_htiming_pkg.sv
package osd_htiming_pkg;

    localparam int CHARS_PER_ROW = 24;
    localparam int DOTS_PER_CHAR = 12;
    localparam int DELAY_STEP    = 6;
    localparam int DELAY_BASE    = 49;
    localparam int COL_W         = $clog2(CHARS_PER_ROW);
    localparam int DOT_W         = $clog2(DOTS_PER_CHAR);

    // Position of the beam inside the character window
    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [DOT_W-1:0] dot;
        logic             half;   // second clock of a doubled dot
    } cell_pos_t;

    // Start offset of the window, clamped so it never goes negative
    function automatic int start_delay(int hpos, int pulse);
        int d;
        d = hpos * DELAY_STEP + DELAY_BASE - pulse;
        return (d < 0) ? 0 : d;
    endfunction

    function automatic int window_len(logic wide);
        return CHARS_PER_ROW * DOTS_PER_CHAR * (wide ? 2 : 1);
    endfunction

    function automatic int line_len(int hres);
        return hres * DOTS_PER_CHAR;
    endfunction

endpackage

// File: rtl/osd_hline_counter.sv
module osd_hline_counter #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    output logic             restart,
    output logic [CNT_W-1:0] pos
);

    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    assign restart = sync_in & ~sync_q;

    // Position counter: cleared on a sync edge, otherwise counts up and sticks at the top
    always_ff @(posedge clk) begin
        if (rst)               pos <= '1;
        else if (restart)      pos <= '0;
        else if (pos != '1)    pos <= pos + 1'b1;
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!restart && pos != '1) |=> (pos == CNT_W'($past(pos) + 1'b1)));

endmodule

// File: rtl/osd_hwindow.sv
module osd_hwindow
    import osd_htiming_pkg::*;
#(
    parameter int HPOS_W = 6,
    parameter int HRES_W = 8,
    parameter int CNT_W  = 13,
    parameter int PULSE  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CNT_W-1:0]  pos,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [HRES_W-1:0] hres,
    input  logic              wide,
    output logic              den,
    output logic [COL_W-1:0]  col,
    output logic [DOT_W-1:0]  dot
);

    int        p, d, w, len;
    logic      open;
    cell_pos_t cur, nxt;
    logic      step;

    always_comb begin
        p    = int'(pos);
        d    = start_delay(int'(hpos), PULSE);
        w    = window_len(wide);
        len  = line_len(int'(hres));
        open = (p >= d) && (p < d + w) && (p < len);
    end

    always_comb begin
        nxt  = cur;
        step = !wide || cur.half;
        if (wide) nxt.half = ~cur.half;
        else      nxt.half = 1'b0;
        if (step) begin
            if (cur.dot == DOT_W'(DOTS_PER_CHAR - 1)) begin
                nxt.dot = '0;
                nxt.col = (cur.col == COL_W'(CHARS_PER_ROW - 1)) ? '0 : cur.col + 1'b1;
            end else begin
                nxt.dot = cur.dot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !open) cur <= '0;
        else                         cur <= nxt;
    end

    assign den = open;
    assign col = open ? cur.col : '0;
    assign dot = open ? cur.dot : '0;

    p_den_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(den) |-> (col == '0 && dot == '0));

    p_col_range_r4: assert property (@(posedge clk) disable iff (rst)
        den |-> (col < COL_W'(CHARS_PER_ROW)));

    p_dot_range_r4: assert property (@(posedge clk) disable iff (rst)
        den |-> (dot < DOT_W'(DOTS_PER_CHAR)));

    p_wide_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (den && wide && $past(den) && $past(wide) && !$past(restart) && !$past(cur.half))
        |-> (dot == $past(dot)));

endmodule

// File: rtl/osd_htiming.sv
module osd_htiming
    import osd_htiming_pkg::*;
#(
    parameter int HPOS_W      = 6,
    parameter int HRES_W      = 8,
    parameter int PHASE_PULSE = 4,
    localparam int LINE_MAX   = (2 ** HRES_W - 1) * DOTS_PER_CHAR,
    localparam int CNT_W      = $clog2(LINE_MAX + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_sync,
    input  logic [HPOS_W-1:0] hpos_reg,
    input  logic [HRES_W-1:0] hres_reg,
    input  logic              wide_mode,
    output logic              disp_en,
    output logic [COL_W-1:0]  char_col,
    output logic [DOT_W-1:0]  char_dot,
    output logic [CNT_W-1:0]  line_pos
);

    logic restart;

    osd_hline_counter #(
        .CNT_W (CNT_W)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .sync_in (line_sync),
        .restart (restart),
        .pos     (line_pos)
    );

    osd_hwindow #(
        .HPOS_W (HPOS_W),
        .HRES_W (HRES_W),
        .CNT_W  (CNT_W),
        .PULSE  (PHASE_PULSE)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .pos     (line_pos),
        .hpos    (hpos_reg),
        .hres    (hres_reg),
        .wide    (wide_mode),
        .den     (disp_en),
        .col     (char_col),
        .dot     (char_dot)
    );

    p_clip_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(line_pos) >= int'(hres_reg) * DOTS_PER_CHAR) |-> !disp_en);

endmodule

// File: tb/sim_osd_htiming.sv
module sim_osd_htiming;

    localparam int PULSE = 60;
    localparam int MAXP  = 8191;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_sync = 1'b0;
    logic [5:0] hpos_reg = '0;
    logic [7:0] hres_reg = 8'd40;
    logic       wide_mode = 1'b0;
    logic       disp_en;
    logic [4:0] char_col;
    logic [3:0] char_dot;
    logic [12:0] line_pos;

    int    total = 0;
    int    bad = 0;
    string cur_tag = "R3";
    bit    armed = 0;
    bit    done = 0;

    osd_htiming #(.HPOS_W(6), .HRES_W(8), .PHASE_PULSE(PULSE)) u0 (
        .clk(clk), .rst(rst), .line_sync(line_sync), .hpos_reg(hpos_reg),
        .hres_reg(hres_reg), .wide_mode(wide_mode), .disp_en(disp_en),
        .char_col(char_col), .char_dot(char_dot), .line_pos(line_pos)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (model pos=%0d)", tag, what, act, exp, m_pos);
        end
    endtask

    // Behavioural reference: a plain integer position and arithmetic on it
    int m_pos = MAXP;
    bit m_sync_q = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = MAXP;
            m_sync_q = 0;
        end else begin
            if (line_sync && !m_sync_q) m_pos = 0;
            else if (m_pos < MAXP)      m_pos++;
            m_sync_q = line_sync;
        end
        armed = 1;
    end

    always begin
        @(negedge clk);
        #1;
        if (armed && !rst && !done) begin
            int d, w, len, o, e_col, e_dot;
            bit e_den;
            d = int'(hpos_reg) * 6 + 49 - PULSE;
            if (d < 0) d = 0;
            w = wide_mode ? 576 : 288;
            len = int'(hres_reg) * 12;
            o = m_pos - d;
            e_den = (m_pos >= d) && (m_pos < d + w) && (m_pos < len);
            e_col = !e_den ? 0 : (wide_mode ? o / 24 : o / 12);
            e_dot = !e_den ? 0 : (wide_mode ? (o % 24) / 2 : o % 12);
            chk((cur_tag == "R9") ? "R9" : "R2", "line_pos", int'(line_pos), m_pos);
            chk(cur_tag, "disp_en", int'(disp_en), int'(e_den));
            chk(!e_den ? "R7" : (wide_mode ? "R5" : "R4"), "char_col", int'(char_col), e_col);
            chk(!e_den ? "R7" : (wide_mode ? "R5" : "R4"), "char_dot", int'(char_dot), e_dot);
        end
    end

    // Sync rise, then new settings in the cycle where the position reads 0
    task automatic do_line(int hp, int hr, bit wd, int n, int hold, string tag);
        @(negedge clk);
        line_sync = 1'b1;
        @(negedge clk);
        hpos_reg = 6'(hp);
        hres_reg = 8'(hr);
        wide_mode = wd;
        cur_tag = tag;
        repeat (hold - 1) @(negedge clk);
        line_sync = 1'b0;
        repeat (n - hold) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset values
        chk("R1", "line_pos", int'(line_pos), MAXP);
        chk("R1", "disp_en", int'(disp_en), 0);
        chk("R1", "char_col", int'(char_col), 0);
        chk("R1", "char_dot", int'(char_dot), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R3/R4: narrow window, delay 49
        do_line(10, 40, 1'b0, 480, 4, "R3");
        do_line(10, 40, 1'b0, 480, 4, "R3");
        // R3: delay clamps to zero
        do_line(0, 30, 1'b0, 360, 2, "R3");
        do_line(0, 30, 1'b0, 360, 2, "R3");
        // R5: wide window
        do_line(5, 60, 1'b1, 720, 3, "R5");
        do_line(5, 60, 1'b1, 720, 3, "R5");
        // R6: line ends inside the window, narrow and wide
        do_line(30, 30, 1'b0, 420, 3, "R6");
        do_line(2, 40, 1'b1, 520, 3, "R6");
        // R8: restart mid-window, then a full line
        do_line(10, 40, 1'b0, 200, 3, "R8");
        do_line(10, 40, 1'b0, 480, 3, "R8");
        do_line(0, 40, 1'b0, 150, 3, "R8");
        do_line(0, 40, 1'b0, 400, 3, "R8");
        // R9: sync held high across most of a line
        do_line(10, 40, 1'b0, 520, 500, "R9");
        // R2: no sync for a long time, counter saturates
        do_line(10, 255, 1'b0, 8400, 2, "R2");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule